// File: doc/BRIEF.md
# Decimal32 Operand Unpacker for Logarithm

This block takes one 32-bit IEEE 754-2008 decimal32 word whose coefficient is held in densely packed decimal (DPD) form. It splits the word into a sign, an 8-bit biased exponent and a seven-digit BCD coefficient, and it gives a 2-bit exception code that says whether a logarithm unit downstream can use the operand.

The classification is aimed at a logarithm, not at general decoding. Any operand with the sign bit set becomes NaN. A NaN encoding becomes NaN. A finite operand whose decoded coefficient is zero becomes NaN, whatever its exponent. Positive infinity passes through as infinity. The field decode is combinational. A parameter can add one output register, which is the default; that register is loaded on `in_valid` and marked by `out_valid`.

Top module: `dec32_log_unpack`

## Requirements
- R1: `out_sign` equals bit 31 of the accepted word, for every encoding class, NaN and infinity included.
- R2: When bits 30:29 are not both 1, `out_exp` is {bits 30:29, bits 25:20}, and the leading coefficient digit is the value of bits 28:26 (0 to 7).
- R3: When bits 30:29 are both 1 and bits 28:27 are not both 1, `out_exp` is {bits 28:27, bits 25:20}, and the leading digit is 8 plus bit 26. The input 0x6DE3FCFF gives sign 0, `out_exp` 94 (8'h5E) and coefficient 9999999.
- R4: Each 10-bit group is decoded with the standard DPD mapping, using bit 3 as the first indicator, bits 2:1 as the second and bits 6:5 as the third. All eight size classes of digits (each digit either 0 to 7 or 8 to 9) decode correctly. Non-canonical patterns, for example 0x3FF giving 999 and 0x3FE giving 998, never give a digit above 9.
- R5: `out_coef` holds the leading digit in bits 27:24. Bits 23:12 hold the group in word bits 19:10. Bits 11:0 hold the group in word bits 9:0. The most significant digit of each group is in the upper nibble of that group.
- R6: `out_exc` is 2'b00 for normal, 2'b01 for infinity and 2'b10 for NaN, and it is never 2'b11. Bits 30:26 = 11110 with sign 0 gives 2'b01. Bits 30:26 = 11111 gives 2'b10.
- R7: Any word with bit 31 set gives 2'b10, negative infinity included.
- R8: A finite word whose decoded coefficient is zero gives 2'b10 for every exponent, 0 and 191 included. A finite, positive, nonzero word gives 2'b00.
- R9: For infinity and NaN encodings (bits 30:27 = 1111), `out_exp` and `out_coef` are zero, whatever the trailing bits hold.
- R10: With the output register on, the result for a word accepted on `in_valid` appears on the next clock edge with `out_valid` high. `out_valid` is low after any cycle without `in_valid`. Reset clears `out_valid` and all output fields to zero, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept `in_word` this cycle |
| in_word | input | 32 | Decimal32 operand, DPD coefficient encoding |
| out_valid | output | 1 | Output fields hold a fresh result |
| out_sign | output | 1 | Sign bit of the operand |
| out_exp | output | 8 | Biased exponent (bias 101) |
| out_coef | output | 28 | Seven BCD digits, most significant first |
| out_exc | output | 2 | 00 normal, 01 infinity, 10 NaN |

## Verification
Some words meet two classification rules at once, and those are where the precedence matters. Negative infinity (0xF8000000) is both an infinity encoding and a negative operand. A negative zero is a negative operand and a zero coefficient. The bench sends these words back to back with single-rule cases. For each one it expects NaN, with the sign preserved. For the special encodings it also expects the exponent and coefficient fields to be cleared. A scoreboard compares all four output fields against values that the bench computes by encoding digits into DPD.

// File: rtl/d32u_pkg.sv
package d32u_pkg;

   typedef enum logic [1:0] {
      EXC_NORMAL = 2'b00,
      EXC_INF    = 2'b01,
      EXC_NAN    = 2'b10
   } exc_e;

   localparam int unsigned DPD_IN_W  = 10;
   localparam int unsigned DPD_OUT_W = 12;
   localparam int unsigned COMBO_W   = 5;

endpackage

// File: rtl/d32u_dpd_group.sv
module d32u_dpd_group
   import d32u_pkg::*;
(
   input  logic [DPD_IN_W-1:0]  dpd,
   output logic [DPD_OUT_W-1:0] bcd
);

   logic [3:0] d_hi, d_mid, d_lo;

   always_comb begin
      d_hi  = {1'b0, dpd[9:7]};
      d_mid = {1'b0, dpd[6:4]};
      d_lo  = {1'b0, dpd[2:0]};
      if (dpd[3]) begin
         unique case (dpd[2:1])
            2'b00: d_lo = {3'b100, dpd[0]};
            2'b01: begin
               d_mid = {3'b100, dpd[4]};
               d_lo  = {1'b0, dpd[6:5], dpd[0]};
            end
            2'b10: begin
               d_hi = {3'b100, dpd[7]};
               d_lo = {1'b0, dpd[9:8], dpd[0]};
            end
            default: begin
               unique case (dpd[6:5])
                  2'b00: begin
                     d_hi  = {3'b100, dpd[7]};
                     d_mid = {3'b100, dpd[4]};
                     d_lo  = {1'b0, dpd[9:8], dpd[0]};
                  end
                  2'b01: begin
                     d_hi  = {3'b100, dpd[7]};
                     d_mid = {1'b0, dpd[9:8], dpd[4]};
                     d_lo  = {3'b100, dpd[0]};
                  end
                  2'b10: begin
                     d_mid = {3'b100, dpd[4]};
                     d_lo  = {3'b100, dpd[0]};
                  end
                  default: begin
                     d_hi  = {3'b100, dpd[7]};
                     d_mid = {3'b100, dpd[4]};
                     d_lo  = {3'b100, dpd[0]};
                  end
               endcase
            end
         endcase
      end
   end

   assign bcd = {d_hi, d_mid, d_lo};

   always_comb begin
      // R4
      digit_bound_chk: assert (bcd[11:8] <= 4'd9 && bcd[7:4] <= 4'd9 && bcd[3:0] <= 4'd9);
   end

endmodule

// File: rtl/d32u_combo_dec.sv
module d32u_combo_dec
   import d32u_pkg::*;
(
   input  logic [COMBO_W-1:0] combo,
   output logic [1:0]         exp_msb,
   output logic [3:0]         lead_digit,
   output logic               is_inf,
   output logic               is_nan
);

   logic large_lead;

   always_comb begin
      large_lead = (combo[4:3] == 2'b11);
      is_inf     = (combo == 5'b11110);
      is_nan     = (combo == 5'b11111);
      if (large_lead) begin
         exp_msb    = combo[2:1];
         lead_digit = {3'b100, combo[0]};
      end else begin
         exp_msb    = combo[4:3];
         lead_digit = {1'b0, combo[2:0]};
      end
   end

   always_comb begin
      // R3
      lead_range_chk: assert (lead_digit <= 4'd9);
      // R6
      special_excl_chk: assert (!(is_inf && is_nan));
   end

endmodule

// File: rtl/d32u_classify.sv
module d32u_classify
   import d32u_pkg::*;
#(
   parameter int unsigned COEF_W = 28
)(
   input  logic              sign,
   input  logic              is_inf,
   input  logic              is_nan,
   input  logic [COEF_W-1:0] coef,
   output exc_e              exc
);

   logic coef_zero;

   always_comb begin
      coef_zero = (coef == '0);
      if (is_nan || sign || (!is_inf && coef_zero))
         exc = EXC_NAN;
      else if (is_inf)
         exc = EXC_INF;
      else
         exc = EXC_NORMAL;
   end

   always_comb begin
      // R6
      exc_code_chk: assert ($onehot0(exc));
      // R8
      zero_not_normal_chk: assert (!(coef_zero && exc == EXC_NORMAL));
   end

endmodule

// File: rtl/dec32_log_unpack.sv
module dec32_log_unpack
   import d32u_pkg::*;
#(
   parameter int unsigned DPD_GROUPS = 2,
   parameter int unsigned EXP_CONT_W = 6,
   parameter int unsigned OUT_REG    = 1,
   localparam int unsigned DIGITS    = 1 + 3 * DPD_GROUPS,
   localparam int unsigned COEF_W    = 4 * DIGITS,
   localparam int unsigned EXP_W     = EXP_CONT_W + 2,
   localparam int unsigned TRAIL_W   = DPD_IN_W * DPD_GROUPS,
   localparam int unsigned WORD_W    = 1 + COMBO_W + EXP_CONT_W + TRAIL_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   output logic              out_sign,
   output logic [EXP_W-1:0]  out_exp,
   output logic [COEF_W-1:0] out_coef,
   output logic [1:0]        out_exc
);

   localparam int unsigned SIGN_BIT = WORD_W - 1;
   localparam int unsigned COMBO_HI = WORD_W - 2;
   localparam int unsigned ECONT_HI = WORD_W - 2 - COMBO_W;
   localparam int unsigned EXP_MAX  = 3 * (2 ** EXP_CONT_W) - 1;

   if (DPD_GROUPS < 1) begin : g_bad_groups
      $error("DPD_GROUPS must be at least 1");
   end
   if (EXP_CONT_W < 1) begin : g_bad_econt
      $error("EXP_CONT_W must be at least 1");
   end
   if (OUT_REG > 1) begin : g_bad_outreg
      $error("OUT_REG must be 0 or 1");
   end

   logic [COMBO_W-1:0]    in_combo;
   logic [EXP_CONT_W-1:0] in_exp_cont;
   logic [1:0]            exp_msb;
   logic [3:0]            lead_digit;
   logic                  is_inf, is_nan, is_special;
   logic [TRAIL_W/DPD_IN_W*DPD_OUT_W-1:0] trail_bcd;
   logic [COEF_W-1:0]     coef_dec, coef_n;
   logic [EXP_W-1:0]      exp_n;
   exc_e                  exc_n;

   assign in_combo    = in_word[COMBO_HI -: COMBO_W];
   assign in_exp_cont = in_word[ECONT_HI -: EXP_CONT_W];

   d32u_combo_dec u_combo (
      .combo      (in_combo),
      .exp_msb    (exp_msb),
      .lead_digit (lead_digit),
      .is_inf     (is_inf),
      .is_nan     (is_nan)
   );

   for (genvar g = 0; g < DPD_GROUPS; g++) begin : g_dpd
      d32u_dpd_group u_grp (
         .dpd (in_word[g*DPD_IN_W +: DPD_IN_W]),
         .bcd (trail_bcd[g*DPD_OUT_W +: DPD_OUT_W])
      );
   end

   assign coef_dec   = {lead_digit, trail_bcd};
   assign is_special = is_inf | is_nan;
   assign exp_n      = is_special ? '0 : {exp_msb, in_exp_cont};
   assign coef_n     = is_special ? '0 : coef_dec;

   d32u_classify #(.COEF_W(COEF_W)) u_class (
      .sign   (in_word[SIGN_BIT]),
      .is_inf (is_inf),
      .is_nan (is_nan),
      .coef   (coef_n),
      .exc    (exc_n)
   );

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_sign  <= 1'b0;
            out_exp   <= '0;
            out_coef  <= '0;
            out_exc   <= EXC_NORMAL;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_sign <= in_word[SIGN_BIT];
               out_exp  <= exp_n;
               out_coef <= coef_n;
               out_exc  <= exc_n;
            end
         end
      end

      // R10
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R10
      idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R2
      small_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_combo[4:3] != 2'b11) |=>
            (out_exp == $past({in_combo[4:3], in_exp_cont})));
      // R7
      neg_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_word[SIGN_BIT]) |=> (out_exc == EXC_NAN));
      // R6
      inf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !in_word[SIGN_BIT] && in_combo == 5'b11110) |=> (out_exc == EXC_INF));
      // R9
      special_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_combo[4:1] == 4'b1111) |=> (out_exp == '0 && out_coef == '0));
      // R8
      normal_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_exc == EXC_NORMAL) |-> (out_coef != '0 && out_exp <= EXP_W'(EXP_MAX)));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_sign  = in_word[SIGN_BIT];
      assign out_exp   = exp_n;
      assign out_coef  = coef_n;
      assign out_exc   = exc_n;
   end

endmodule

// File: tb/dec32_log_unpack_tb.sv
module dec32_log_unpack_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_word;
   logic        out_valid, out_sign;
   logic [7:0]  out_exp;
   logic [27:0] out_coef;
   logic [1:0]  out_exc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic        q_s[$];
   logic [7:0]  q_e[$];
   logic [27:0] q_c[$];
   logic [1:0]  q_x[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   dec32_log_unpack u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
      .out_coef(out_coef), .out_exc(out_exc)
   );

   function automatic logic [9:0] enc3(logic [11:0] g);
      logic [3:0] a, b, c;
      a = g[11:8]; b = g[7:4]; c = g[3:0];
      case ({a > 4'd7, b > 4'd7, c > 4'd7})
         3'b000: return {a[2:0], b[2:0], 1'b0, c[2:0]};
         3'b001: return {a[2:0], b[2:0], 3'b100, c[0]};
         3'b010: return {a[2:0], c[2:1], b[0], 3'b101, c[0]};
         3'b100: return {c[2:1], a[0], b[2:0], 3'b110, c[0]};
         3'b110: return {c[2:1], a[0], 2'b00, b[0], 3'b111, c[0]};
         3'b101: return {b[2:1], a[0], 2'b01, b[0], 3'b111, c[0]};
         3'b011: return {a[2:0], 2'b10, b[0], 3'b111, c[0]};
         default: return {2'b00, a[0], 2'b11, b[0], 3'b111, c[0]};
      endcase
   endfunction

   function automatic logic [31:0] build(logic s, logic [7:0] e, logic [27:0] c);
      logic [3:0] ld;
      logic [4:0] cb;
      ld = c[27:24];
      if (ld > 4'd7) cb = {2'b11, e[7:6], ld[0]};
      else           cb = {e[7:6], ld[2:0]};
      return {s, cb, e[5:0], enc3(c[23:12]), enc3(c[11:0])};
   endfunction

   task automatic send(logic [31:0] w, logic s, logic [7:0] e, logic [27:0] c,
                       logic [1:0] x, string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      q_s.push_back(s); q_e.push_back(e); q_c.push_back(c);
      q_x.push_back(x); q_tag.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_valid === 1'b1) begin
         checks++;
         if (q_s.size() == 0) begin
            failures++;
            $display("FAIL R10: out_valid high with no pending item (got 1, expected 0)");
         end else begin
            logic s; logic [7:0] e; logic [27:0] c; logic [1:0] x; string t;
            s = q_s.pop_front(); e = q_e.pop_front(); c = q_c.pop_front();
            x = q_x.pop_front(); t = q_tag.pop_front();
            if (out_sign !== s || out_exp !== e || out_coef !== c || out_exc !== x) begin
               failures++;
               $display("FAIL %s: got s=%0b e=%0d c=%h x=%b expected s=%0b e=%0d c=%h x=%b",
                        t, out_sign, out_exp, out_coef, out_exc, s, e, c, x);
            end
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b1; in_word = 32'h6DE3FCFF;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_exp !== 8'd0 || out_coef !== 28'd0 || out_exc !== 2'b00) begin
         failures++;
         $display("FAIL R10 reset: got v=%b e=%0d c=%h x=%b expected v=0 e=0 c=0 x=00",
                  out_valid, out_exp, out_coef, out_exc);
      end
      in_valid = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      idle(1);

      send(32'h6DE3FCFF, 1'b0, 8'd94, 28'h9999999, 2'b00, "R3 example word");
      send(build(0, 8'd101, 28'h1000000), 1'b0, 8'd101, 28'h1000000, 2'b00, "R2 small lead");
      send(build(0, 8'd0, 28'h0000001), 1'b0, 8'd0, 28'h0000001, 2'b00, "R8 min nonzero");
      send(build(0, 8'd191, 28'h9812765), 1'b0, 8'd191, 28'h9812765, 2'b00, "R3 max exp large lead");
      idle(2);
      send(build(0, 8'd50, 28'h5829398), 1'b0, 8'd50, 28'h5829398, 2'b00, "R4 classes 101/011");
      send(build(0, 8'd77, 28'h3991239), 1'b0, 8'd77, 28'h3991239, 2'b00, "R4 classes 110/001");
      send(build(0, 8'd130, 28'h7999485), 1'b0, 8'd130, 28'h7999485, 2'b00, "R5 classes 111/010");
      send({1'b0, 5'b00010, 6'd0, 10'h3FF, 10'h3FE}, 1'b0, 8'd0, 28'h2999998, 2'b00, "R4 noncanonical");
      send(32'h78000000, 1'b0, 8'd0, 28'd0, 2'b01, "R6 positive inf");
      send(32'h7BFFFFFF, 1'b0, 8'd0, 28'd0, 2'b01, "R9 inf trailing bits");
      send(32'h7C000000, 1'b0, 8'd0, 28'd0, 2'b10, "R6 quiet nan");
      send(32'hFFFFFFFF, 1'b1, 8'd0, 28'd0, 2'b10, "R1 negative nan");
      send(32'hF8000000, 1'b1, 8'd0, 28'd0, 2'b10, "R7 negative inf");
      send(build(1, 8'd94, 28'h1234567), 1'b1, 8'd94, 28'h1234567, 2'b10, "R7 negative finite");
      send(build(0, 8'd191, 28'h0000000), 1'b0, 8'd191, 28'h0000000, 2'b10, "R8 zero max exp");
      send(build(0, 8'd0, 28'h0000000), 1'b0, 8'd0, 28'h0000000, 2'b10, "R8 zero min exp");
      send(build(1, 8'd101, 28'h0000000), 1'b1, 8'd101, 28'h0000000, 2'b10, "R7 negative zero");
      idle(4);

      checks++;
      if (q_s.size() != 0) begin
         failures++;
         $display("FAIL R10: pending results got %0d expected 0", q_s.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R10 watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule